// File: doc/BRIEF.md
# Dual-Buffer Ethernet Frame Receiver with Destination Filter

This block is the receive half of a small memory-mapped Ethernet MAC. Frame bytes arrive one per beat on a byte stream that marks the first and last byte of each frame, with an error flag that travels with the last byte. While a frame streams in, the block compares its destination address against a station address supplied by the surrounding MAC. Frames sent to a group address are accepted without that comparison. The bytes are written into one of two receive buffers.

Each buffer has a control word with a full flag. The block sets this flag when an accepted frame has been fully stored. Software reads the frame over a 32-bit register bus and then gives the buffer back by clearing the flag. A frame that arrives while its target buffer is still full is thrown away and the buffer is left as it was. With alternating mode on, each accepted frame moves reception to the other buffer, so software can drain one buffer while the next frame fills the other. An interrupt pulse can announce each stored frame.

The register window is counted in 32-bit words. Each buffer takes `SPAN_WORDS` words, which must be a power of two. The last word of each span is the buffer's control word and the words below it hold frame data.

Top module: `rxpp_receiver`

## Requirements
- R1: After reset, buffer 0 is the target buffer, both full flags (bit 0) and interrupt-enable bits (bit 3) of the control words read 0, the global enable word reads 0, and `irq` is low.
- R2: A frame is accepted only if it has at least 6 bytes and either bit 0 of its first byte is 1 (group address) or its first six bytes equal `station_mac`, with `station_mac[47:40]` compared against the first byte. Any other frame leaves the full flags, the target buffer and `irq` unchanged.
- R3: Frame byte k (k = 0 for the start byte) is written to data word k/4 of the target buffer, in bits 8*(k%4)+7 down to 8*(k%4). Data word w of buffer b is read at `reg_addr` = b*SPAN_WORDS + w.
- R4: The control word of buffer b sits at `reg_addr` = b*SPAN_WORDS + SPAN_WORDS-1, with the full flag in bit 0 and the interrupt enable in bit 3; all other bits read 0. The full flag of the target buffer is set on the clock edge that takes the last byte of an accepted frame.
- R5: If the target buffer's full flag is 1 on the start byte of a frame, the whole frame is dropped. The buffer's data, the full flags and the target buffer stay unchanged, and no interrupt follows.
- R6: With `pingpong_en` high, the target buffer switches to the other buffer after each accepted frame and stays put otherwise. With `pingpong_en` low, frames always go to buffer 0.
- R7: `irq` is high for exactly the one cycle after the last byte of an accepted frame, and only if bit 3 of buffer 0's control word and bit 31 of the global enable word are both 1. This holds whichever buffer received the frame.
- R8: A bus write to a control word loads its bit 0 and bit 3 from `reg_wdata`. Writing bit 0 as 0 releases the buffer. If a store completes in the same cycle, the full flag set by the hardware takes priority.
- R9: Bytes at positions at or beyond (SPAN_WORDS-1)*4 are not stored. A frame truncated this way is still accepted and marked full.
- R10: A frame whose last byte has `rx_err` high is discarded, like a filtered frame.
- R11: The global enable word is at any `reg_addr` with the top bit set, and only its bit 31 is kept. `reg_rdata` shows the addressed word in the cycle after `reg_rd`. Bus writes to data words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pingpong_en | input | 1 | Alternate between the two buffers after each accepted frame |
| station_mac | input | 48 | Station address, first byte in bits 47:40 |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_err | input | 1 | Error flag, sampled with the last byte |
| rx_data | input | 8 | Frame byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address in the receive window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| irq | output | 1 | One-cycle frame-received interrupt pulse |

## Verification
The hardest state to reach from the ports is a frame arriving while its target buffer is still full, particularly in alternating mode, where that requires both buffers to be full.

The bench sweeps frame length (short, exactly six bytes, around the truncation edge, and past it), the byte at which the destination compare fails, group addressing and the error flag. It frees the buffers only after every third frame, so buffers fill up and later frames meet full targets in both modes.

A bench model decides from the requirements whether each frame is kept, dropped or filtered. It then checks the interrupt pulse, both control words and every stored byte of the target buffer.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  localparam int DEST_LEN = 6;
  localparam int FULL_BIT = 0;
  localparam int IE_BIT   = 3;
  localparam int GIE_BIT  = 31;

  // Byte idx of the station address, first byte in the top octet
  function automatic logic [7:0] mac_byte(input logic [47:0] mac, input int unsigned idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < DEST_LEN; i++) begin
      if (idx == i) r = mac[47-8*i -: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic full, input logic ie);
    logic [31:0] w;
    w = '0;
    w[FULL_BIT] = full;
    w[IE_BIT]   = ie;
    return w;
  endfunction

  function automatic logic [31:0] gie_word(input logic en);
    logic [31:0] w;
    w = '0;
    w[GIE_BIT] = en;
    return w;
  endfunction

endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter
  import rxpp_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      station_mac,
  input  logic             beat,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [7:0]       data,
  output logic             accept_now
);

  logic grp_q, miss_q;
  logic first, in_dest, grp_c, miss_c, long_enough;

  always_comb begin
    first       = (cur_pos == '0);
    in_dest     = (cur_pos < POS_W'(DEST_LEN));
    grp_c       = first ? data[0] : grp_q;
    miss_c      = (first ? 1'b0 : miss_q) |
                  (in_dest && (data != mac_byte(station_mac, int'(cur_pos))));
    long_enough = (cur_pos >= POS_W'(DEST_LEN - 1));
    accept_now  = long_enough && (grp_c || !miss_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= 1'b0;
      miss_q <= 1'b0;
    end else if (beat) begin
      grp_q  <= grp_c;
      miss_q <= miss_c;
    end
  end

endmodule

// File: rtl/rxpp_buf_bank.sv
module rxpp_buf_bank #(
  parameter int DATA_WORDS = 511,
  parameter int IDX_W      = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_word,
  input  logic [1:0]       wr_lane,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_word,
  output logic [31:0]      rd_data
);

  logic [3:0][7:0] mem [DATA_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_word) < DATA_WORDS)) mem[wr_word][wr_lane] <= wr_byte;
  end

  always_comb begin
    if (int'(rd_word) < DATA_WORDS) rd_data = mem[rd_word];
    else                            rd_data = '0;
  end

endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pingpong_en,
  input  logic       frame_done,
  input  logic [1:0] sw_ctrl_we,
  input  logic       sw_full,
  input  logic       sw_ie,
  input  logic       gie_we,
  input  logic       gie_val,
  output logic [1:0] full_bits,
  output logic [1:0] ie_bits,
  output logic       gie,
  output logic       act_idx,
  output logic       tgt_idx,
  output logic       irq
);

  assign tgt_idx = pingpong_en ? act_idx : 1'b0;

  for (genvar b = 0; b < 2; b++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_bits[b] <= 1'b0;
        ie_bits[b]   <= 1'b0;
      end else begin
        if (sw_ctrl_we[b]) ie_bits[b] <= sw_ie;
        if (frame_done && (tgt_idx == 1'(b))) full_bits[b] <= 1'b1;
        else if (sw_ctrl_we[b])               full_bits[b] <= sw_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      act_idx <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (gie_we) gie <= gie_val;
      if (frame_done) act_idx <= pingpong_en ? ~act_idx : 1'b0;
      irq <= frame_done && ie_bits[0] && gie;
    end
  end

endmodule

// File: rtl/rxpp_receiver.sv
module rxpp_receiver
  import rxpp_pkg::*;
#(
  parameter  int SPAN_WORDS = 512,
  localparam int ADDR_W     = $clog2(SPAN_WORDS) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pingpong_en,
  input  logic [47:0]       station_mac,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int SPAN_W     = $clog2(SPAN_WORDS);
  localparam int DATA_WORDS = SPAN_WORDS - 1;
  localparam int DATA_BYTES = DATA_WORDS * 4;
  localparam int POS_W      = $clog2(DATA_BYTES + 1);

  // frame tracking
  logic             in_frame_q, drop_q;
  logic [POS_W-1:0] pos_q, cur_pos;
  logic             start_beat, cont_beat, frame_beat, drop_c;
  logic             store_en, frame_end, frame_done, accept_now;
  logic [SPAN_W-1:0] wr_word;
  logic [1:0]        wr_lane;

  // control state
  logic [1:0] full_bits, ie_bits, sw_ctrl_we;
  logic       gie, act_idx, tgt_idx, gie_we;

  // bus decode
  logic              gie_sel, buf_sel, is_ctrl;
  logic [SPAN_W-1:0] rd_word;
  logic [31:0]       bank_rd [2];
  logic [31:0]       rd_mux;
  logic              wdata_unused;

  assign wdata_unused = ^{reg_wdata[30:4], reg_wdata[2:1]};

  always_comb begin
    start_beat = rx_valid && rx_sof;
    cont_beat  = rx_valid && !rx_sof && in_frame_q;
    frame_beat = start_beat || cont_beat;
    cur_pos    = start_beat ? '0 : pos_q;
    drop_c     = start_beat ? full_bits[tgt_idx] : drop_q;
    store_en   = frame_beat && !drop_c && (cur_pos < POS_W'(DATA_BYTES));
    frame_end  = frame_beat && rx_eof;
    frame_done = frame_end && !drop_c && !rx_err && accept_now;
    wr_word    = SPAN_W'(cur_pos >> 2);
    wr_lane    = cur_pos[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      pos_q      <= '0;
    end else if (frame_beat) begin
      in_frame_q <= !rx_eof;
      drop_q     <= drop_c;
      if (cur_pos < POS_W'(DATA_BYTES)) pos_q <= cur_pos + 1'b1;
      else                              pos_q <= cur_pos;
    end
  end

  rxpp_addr_filter #(.POS_W(POS_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .station_mac (station_mac),
    .beat        (frame_beat),
    .cur_pos     (cur_pos),
    .data        (rx_data),
    .accept_now  (accept_now)
  );

  assign gie_sel = reg_addr[ADDR_W-1];
  assign buf_sel = reg_addr[ADDR_W-2];
  assign rd_word = reg_addr[SPAN_W-1:0];
  assign is_ctrl = (rd_word == SPAN_W'(SPAN_WORDS - 1));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign sw_ctrl_we[b] = reg_wr && !gie_sel && is_ctrl && (buf_sel == 1'(b));
    rxpp_buf_bank #(.DATA_WORDS(DATA_WORDS), .IDX_W(SPAN_W)) u_bank (
      .clk     (clk),
      .wr_en   (store_en && (tgt_idx == 1'(b))),
      .wr_word (wr_word),
      .wr_lane (wr_lane),
      .wr_byte (rx_data),
      .rd_word (rd_word),
      .rd_data (bank_rd[b])
    );
  end

  assign gie_we = reg_wr && gie_sel;

  rxpp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pingpong_en (pingpong_en),
    .frame_done  (frame_done),
    .sw_ctrl_we  (sw_ctrl_we),
    .sw_full     (reg_wdata[FULL_BIT]),
    .sw_ie       (reg_wdata[IE_BIT]),
    .gie_we      (gie_we),
    .gie_val     (reg_wdata[GIE_BIT]),
    .full_bits   (full_bits),
    .ie_bits     (ie_bits),
    .gie         (gie),
    .act_idx     (act_idx),
    .tgt_idx     (tgt_idx),
    .irq         (irq)
  );

  always_comb begin
    if (gie_sel)      rd_mux = gie_word(gie);
    else if (is_ctrl) rd_mux = ctrl_word(full_bits[buf_sel], ie_bits[buf_sel]);
    else              rd_mux = bank_rd[buf_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/rxpp_receiver_chk.sv
module rxpp_receiver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pingpong_en,
  input logic       rx_valid,
  input logic       rx_eof,
  input logic       rx_err,
  input logic       frame_done,
  input logic [1:0] full_bits,
  input logic       act_idx,
  input logic       tgt_idx,
  input logic       irq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (full_bits == 2'b00 && !irq && !act_idx));

  // R7
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(frame_done));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> full_bits[$past(tgt_idx)]);

  // R6
  pp_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && pingpong_en) |=> (act_idx != $past(act_idx)));

  // R6
  pp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(act_idx));

  // R10
  err_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && rx_err) |-> !frame_done);

endmodule

bind rxpp_receiver rxpp_receiver_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pingpong_en (pingpong_en),
  .rx_valid    (rx_valid),
  .rx_eof      (rx_eof),
  .rx_err      (rx_err),
  .frame_done  (frame_done),
  .full_bits   (full_bits),
  .act_idx     (act_idx),
  .tgt_idx     (tgt_idx),
  .irq         (irq)
);

// File: tb/tb_rxpp_receiver.sv
`timescale 1ns/1ps
module tb_rxpp_receiver;

  localparam int SPAN = 8;
  localparam int AW   = $clog2(SPAN) + 2;
  localparam int DW   = SPAN - 1;
  localparam int DB   = DW * 4;
  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pingpong_en = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #10 clk = ~clk;

  rxpp_receiver #(.SPAN_WORDS(SPAN)) dut (
    .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .station_mac(MAC),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_data(rx_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] em [2][DB];
  bit         ev [2][DB];
  bit es [2];
  bit ei [2];
  bit eg;
  int act;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] fbyte(input int kind, input int seed, input int k);
    logic [7:0] b;
    if (k < 6) begin
      b = MAC[47-8*k -: 8];
      if (kind >= 1 && kind <= 6 && k == kind - 1) b = b ^ 8'h04;
      if (kind == 7) b = (k == 0) ? (8'h01 | 8'(seed << 1)) : 8'(seed + 3 * k);
    end else begin
      b = 8'(seed * 31 + k * 7);
    end
    return b;
  endfunction

  // R3 R4: compare control words and every stored byte of buffer b
  task automatic check_buffers(input int b, input string tag);
    logic [31:0] d, m, e;
    for (int c = 0; c < 2; c++) begin
      rd(c * SPAN + SPAN - 1, d);
      check({tag, " R4 ctrl"}, d, {28'h0, ei[c], 2'b00, es[c]});
    end
    for (int w = 0; w < DW; w++) begin
      rd(b * SPAN + w, d);
      m = '0; e = '0;
      for (int l = 0; l < 4; l++) begin
        if (ev[b][4*w+l]) begin
          m[8*l +: 8] = 8'hff;
          e[8*l +: 8] = em[b][4*w+l];
        end
      end
      check({tag, " R3 data"}, d & m, e);
    end
  endtask

  // one frame: model, stimulus, interrupt and buffer checks
  task automatic send(input int kind, input int len, input bit err, input int seed);
    int tgt;
    bit drop, acc, exp_irq;
    tgt = pingpong_en ? act : 0;
    drop = es[tgt];                                              // R5
    acc  = (len >= 6) && (kind == 0 || kind == 7) && !err;       // R2 R10
    if (!drop) begin
      for (int k = 0; k < len && k < DB; k++) begin              // R9
        em[tgt][k] = fbyte(kind, seed, k);
        ev[tgt][k] = 1'b1;
      end
    end
    exp_irq = !drop && acc && ei[0] && eg;                       // R7
    if (!drop && acc) begin
      es[tgt] = 1'b1;
      act = pingpong_en ? 1 - act : 0;                           // R6
    end
    for (int k = 0; k < len; k++) begin
      if (k == 3) begin
        @(negedge clk);
        rx_valid = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == len - 1);
      rx_err = (k == len - 1) && err; rx_data = fbyte(kind, seed, k);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    check("R7 irq pulse", {31'h0, irq}, {31'h0, exp_irq});
    @(negedge clk);
    check("R7 irq width", {31'h0, irq}, 32'h0);
    check_buffers(tgt, drop ? "R5" : (acc ? "R2" : "R10"));
  endtask

  task automatic release_all();
    for (int c = 0; c < 2; c++) begin
      if (es[c]) begin
        wr(c * SPAN + SPAN - 1, {28'h0, ei[c], 3'b000});         // R8
        es[c] = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int fi;
    int lens [8] = '{1, 5, 6, 7, 27, 28, 29, 40};
    act = 0; eg = 1'b0; fi = 0;
    for (int b = 0; b < 2; b++) begin
      es[b] = 1'b0; ei[b] = 1'b0;
      for (int k = 0; k < DB; k++) begin em[b][k] = 8'h00; ev[b][k] = 1'b0; end
    end
    repeat (3) @(negedge clk);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    // R1 reset state
    rd(SPAN - 1, d);      check("R1 ctrl0", d, 32'h0);
    rd(2 * SPAN - 1, d);  check("R1 ctrl1", d, 32'h0);
    rd(2 * SPAN, d);      check("R1 gie", d, 32'h0);
    // R11 global enable keeps bit 31 only, any address with top bit
    wr(2 * SPAN + 3, 32'hffff_ffff); eg = 1'b1;
    rd(2 * SPAN, d);      check("R11 gie", d, 32'h8000_0000);
    // R8 control write loads bits 0 and 3
    wr(2 * SPAN - 1, 32'hffff_ffff);
    rd(2 * SPAN - 1, d);  check("R8 ctrl1 set", d, 32'h9);
    wr(2 * SPAN - 1, 32'h0);
    rd(2 * SPAN - 1, d);  check("R8 ctrl1 clear", d, 32'h0);

    for (int p = 0; p < 2; p++) begin
      pingpong_en = p[0];
      if (p == 0) act = 0;
      for (int li = 0; li < 8; li++) begin
        ei[0] = (li % 4 != 3);
        eg    = (li % 4 != 2);
        wr(SPAN - 1, {28'h0, ei[0], 2'b00, es[0]});
        wr(2 * SPAN, {eg, 31'h0});
        for (int kind = 0; kind < 8; kind++) begin
          for (int e = 0; e < 2; e++) begin
            send(kind, lens[li], e[0], fi);
            fi++;
            if (fi % 3 == 2) release_all();
          end
        end
      end
      release_all();
    end

    // R11 writes to data words have no effect
    wr(2, 32'hdead_beef);
    check_buffers(0, "R11");
    wr(SPAN + 1, 32'h1234_5678);
    check_buffers(1, "R11");
    // R6 disabled mode after enabled: frames land in buffer 0
    pingpong_en = 1'b0;
    send(0, 12, 1'b0, 7);
    check("R6 buf0 full", {31'h0, es[0]}, 32'h1);
    release_all();
    send(7, 9, 1'b0, 9);
    release_all();

    summary();
    $finish;
  end

endmodule